// File: doc/BRIEF.md
# Compressed Sub-word and Unary Instruction Expander

This block is a purely combinational decode stage. It takes one 16-bit compressed instruction. When that instruction is one of the supplementary compact forms, the block returns the matching 32-bit base instruction. These forms are:

- byte and halfword loads and stores;
- the in-place zero/sign extensions and the bitwise inversion;
- the compact multiply.

Four elaboration parameters say which optional features the host core has:

- basic bit manipulation;
- the unsigned-word address add;
- multiply;
- a 64-bit register width.

A form whose parent feature is missing is reported as illegal instead of being expanded.

The block sits beside the main compressed decoder in the fetch or decode path. Its three mutually exclusive flags tell that decoder what to do with each input:

- `valid_o`: take `xinstr_o`.
- `illegal_o`: raise an illegal-instruction trap.
- `foreign_o`: the encoding belongs to some other compressed form, so the block's output must be ignored.

Only the eight compressed registers are reachable, so every 3-bit register field selects one of x8..x15.

Top module: `cinstr_expander`

## Requirements
- R1: Every 3-bit register field r is expanded to the 5-bit register number 8+r. The field in bits 9:7 is the base (or source/destination) register. The field in bits 4:2 is the load destination, the store data register, or the multiplier operand.
- R2: An input with bits 1:0 = 00 and bits 15:10 = 100000 expands to `lbu` (opcode 0000011, funct3 100). Its zero-extended byte offset takes offset bit 1 from input bit 5 and offset bit 0 from input bit 6.
- R3: An input with bits 1:0 = 00 and bits 15:10 = 100001 is a halfword load. It is `lhu` (funct3 101) when bit 6 = 0 and `lh` (funct3 001) when bit 6 = 1. Its offset is input bit 5 shifted left by one.
- R4: With bits 1:0 = 00, bits 15:10 = 100010 expands to `sb` (opcode 0100011, funct3 000) with the R2 offset. Bits 15:10 = 100011 expands to `sh` (funct3 001) with the R3 offset. Bit 6 = 1 in the `sh` pattern is illegal.
- R5: With bits 1:0 = 01, bits 15:10 = 100111 and bits 6:2 as a unary selector, the unary forms are always accepted:
  - selector 11000 expands to `andi rd,rd,0xff` (opcode 0010011, funct3 111);
  - selector 11101 expands to `xori rd,rd,-1` (funct3 100).
- R6: The unary selectors 11001, 11010 and 11011 need the bit-manipulation parameter; without it they are illegal.
  - 11001 is sign-extend byte: immediate field 0x604, funct3 001, opcode 0010011.
  - 11010 is zero-extend halfword: funct7 0000100, rs2 0, funct3 100. Its opcode is 0110011 at 32-bit width and 0111011 at 64-bit width.
  - 11011 is sign-extend halfword: immediate field 0x605.
- R7: Selector 11100 expands to the unsigned-word add `funct7 0000100, rs2 x0, funct3 000, opcode 0111011`. It is accepted only when both the address-add parameter and the 64-bit parameter are set.
- R8: With bits 1:0 = 01, bits 15:10 = 100111 and bits 6:5 = 10, the input expands to `mul rd,rd,rs2` (funct7 0000001, funct3 000, opcode 0110011). It is accepted only when the multiply parameter is set.
- R9: Unary selectors 11110 and 11111 are illegal. Whenever `valid_o` is low, `xinstr_o` is all zeros.
- R10: Any input outside the two claimed spaces raises `foreign_o`. The claimed spaces are: bits 1:0 = 00 with bits 15:12 = 1000, and bits 1:0 = 01 with bits 15:10 = 100111 and bit 6 = 1. Exactly one of `valid_o`, `illegal_o` and `foreign_o` is high for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cinstr_i | input | 16 | Compressed instruction to examine |
| xinstr_o | output | 32 | Expanded 32-bit instruction, zero unless valid |
| valid_o | output | 1 | Input is a claimed form that is enabled; expansion is meaningful |
| illegal_o | output | 1 | Input lies in the claimed space but is reserved or its feature is absent |
| foreign_o | output | 1 | Input is not handled by this block |

## Verification
The block holds no state, so any fault shows in the same evaluation as the input that exercises it. It may appear as a wrong expansion word, a flag pattern that is not one-hot, or a gated form leaking through. Typical faults are a swapped offset bit, a stale register bias, or an inverted feature gate. Each of these appears only for the input subset that selects that path. That is why every 16-bit input is applied to all sixteen feature combinations at once and compared against an arithmetic model.

// File: rtl/cx_pkg.sv
// Package: cx_pkg
// Shared widths, base opcodes and field-packing helpers for the compressed
// expander. Assumes the standard 32-bit base-instruction field layout.
package cx_pkg;

    localparam int unsigned CW = 16;  // compressed instruction width
    localparam int unsigned XW = 32;  // expanded instruction width
    localparam int unsigned RW = 5;   // full register index width
    localparam int unsigned PW = 3;   // compressed register index width

    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
    localparam logic [6:0] OPC_OP     = 7'b0110011;
    localparam logic [6:0] OPC_OP32   = 7'b0111011;

    // Expander verdict for one sub-decoder.
    typedef struct packed {
        logic          claim;  // encoding belongs to this sub-decoder
        logic          bad;    // claimed but reserved or gated off
        logic [XW-1:0] word;   // expansion when claim && !bad
    } cx_res_t;

    // Map a compressed 3-bit register number onto x8..x15.
    function automatic logic [RW-1:0] prime_reg(input logic [PW-1:0] r);
        return {2'b01, r};
    endfunction

    // Pack an I-type instruction.
    function automatic logic [XW-1:0] pack_i(input logic [11:0] imm,
        input logic [RW-1:0] rs1, input logic [2:0] f3,
        input logic [RW-1:0] rd, input logic [6:0] opc);
        return {imm, rs1, f3, rd, opc};
    endfunction

    // Pack an S-type instruction.
    function automatic logic [XW-1:0] pack_s(input logic [11:0] imm,
        input logic [RW-1:0] rs2, input logic [RW-1:0] rs1,
        input logic [2:0] f3, input logic [6:0] opc);
        return {imm[11:5], rs2, rs1, f3, imm[4:0], opc};
    endfunction

    // Pack an R-type instruction.
    function automatic logic [XW-1:0] pack_r(input logic [6:0] f7,
        input logic [RW-1:0] rs2, input logic [RW-1:0] rs1,
        input logic [2:0] f3, input logic [RW-1:0] rd, input logic [6:0] opc);
        return {f7, rs2, rs1, f3, rd, opc};
    endfunction

endpackage

// File: rtl/cx_mem_expand.sv
// Module: cx_mem_expand
// Decodes the compact byte/halfword load and store forms (quadrant 00,
// bits 15:12 = 1000) into base loads and stores. Needs no optional feature.
// Assumes the caller zeroes the word when bad is set or claim is clear.
module cx_mem_expand
    import cx_pkg::*;
(
    input  logic [CW-1:0] cin,
    output cx_res_t       res
);

    logic [RW-1:0] base_r;
    logic [RW-1:0] data_r;
    logic [11:0]   off_b;
    logic [11:0]   off_h;
    logic          space;

    // Field extraction shared by all four forms.
    always_comb begin
        base_r = prime_reg(cin[9:7]);
        data_r = prime_reg(cin[4:2]);
        off_b  = {10'd0, cin[5], cin[6]};
        off_h  = {10'd0, cin[5], 1'b0};
        space  = (cin[1:0] == 2'b00) && (cin[15:12] == 4'b1000);
    end

    // Form selection on bits 11:10 and the halfword sub-select in bit 6.
    always_comb begin
        res.claim = space;
        res.bad   = 1'b0;
        res.word  = '0;
        if (space) begin
            unique case (cin[11:10])
                2'b00: res.word = pack_i(off_b, base_r, 3'b100, data_r, OPC_LOAD);
                2'b01: res.word = pack_i(off_h, base_r, cin[6] ? 3'b001 : 3'b101,
                                         data_r, OPC_LOAD);
                2'b10: res.word = pack_s(off_b, data_r, base_r, 3'b000, OPC_STORE);
                2'b11: begin
                    res.bad  = cin[6];
                    res.word = pack_s(off_h, data_r, base_r, 3'b001, OPC_STORE);
                end
                default: res.word = '0;
            endcase
        end
    end

    // Guard: every accepted access addresses a compressed base register.
    always_comb begin
        if (res.claim && !res.bad) begin
            p_base_is_prime_r1: assert (res.word[19:18] == 2'b01)
                else $error("memory form base register outside x8..x15");
        end
    end

endmodule

// File: rtl/cx_alu_expand.sv
// Module: cx_alu_expand
// Decodes the destructive unary forms and the compact multiply (quadrant 01,
// bits 15:10 = 100111, bit 6 = 1). Feature parameters gate each form.
// Assumes bits 6:5 = 0x of the same pattern belong to another decoder.
module cx_alu_expand
    import cx_pkg::*;
#(
    parameter bit HAS_BITMANIP = 1'b1,
    parameter bit HAS_ADDUW    = 1'b1,
    parameter bit HAS_MUL      = 1'b1,
    parameter bit XLEN64       = 1'b1
) (
    input  logic [CW-1:0] cin,
    output cx_res_t       res
);

    localparam logic [6:0] ZEXTH_OPC = XLEN64 ? OPC_OP32 : OPC_OP;
    localparam bit         ZEXTW_OK  = HAS_ADDUW && XLEN64;

    logic [RW-1:0] rsd;
    logic [RW-1:0] rs2;
    logic          space;

    // Field extraction and space match.
    always_comb begin
        rsd   = prime_reg(cin[9:7]);
        rs2   = prime_reg(cin[4:2]);
        space = (cin[1:0] == 2'b01) && (cin[15:10] == 6'b100111) && cin[6];
    end

    // Selector decode with per-feature gating.
    always_comb begin
        res.claim = space;
        res.bad   = 1'b0;
        res.word  = '0;
        if (space) begin
            if (!cin[5]) begin
                res.bad  = !HAS_MUL;
                res.word = pack_r(7'b0000001, rs2, rsd, 3'b000, rsd, OPC_OP);
            end else begin
                unique case (cin[4:2])
                    3'd0: res.word = pack_i(12'h0ff, rsd, 3'b111, rsd, OPC_OPIMM);
                    3'd1: begin
                        res.bad  = !HAS_BITMANIP;
                        res.word = pack_i(12'h604, rsd, 3'b001, rsd, OPC_OPIMM);
                    end
                    3'd2: begin
                        res.bad  = !HAS_BITMANIP;
                        res.word = pack_r(7'b0000100, 5'd0, rsd, 3'b100, rsd, ZEXTH_OPC);
                    end
                    3'd3: begin
                        res.bad  = !HAS_BITMANIP;
                        res.word = pack_i(12'h605, rsd, 3'b001, rsd, OPC_OPIMM);
                    end
                    3'd4: begin
                        res.bad  = !ZEXTW_OK;
                        res.word = pack_r(7'b0000100, 5'd0, rsd, 3'b000, rsd, OPC_OP32);
                    end
                    3'd5: res.word = pack_i(12'hfff, rsd, 3'b100, rsd, OPC_OPIMM);
                    default: res.bad = 1'b1;
                endcase
            end
        end
    end

    // Guards: word-width opcodes only on 64-bit cores; multiply only when present.
    always_comb begin
        if (res.claim && !res.bad) begin
            p_op32_needs_xlen64_r7: assert (res.word[6:0] != OPC_OP32 || XLEN64)
                else $error("32-bit-word opcode emitted on a 32-bit core");
            p_mul_needs_feature_r8: assert (!(res.word[6:0] == OPC_OP &&
                                              res.word[31:25] == 7'b0000001) || HAS_MUL)
                else $error("multiply emitted without multiply support");
        end
    end

endmodule

// File: rtl/cinstr_expander.sv
// Module: cinstr_expander
// Top of the compact sub-word/unary expander. Merges the memory and ALU
// sub-decoders into a one-hot valid/illegal/foreign verdict and a word that
// is zero unless valid. Purely combinational; assumes the two sub-decoder
// spaces are disjoint (they differ in the quadrant bits).
module cinstr_expander
    import cx_pkg::*;
#(
    parameter bit HAS_BITMANIP = 1'b1,
    parameter bit HAS_ADDUW    = 1'b1,
    parameter bit HAS_MUL      = 1'b1,
    parameter bit XLEN64       = 1'b1
) (
    input  logic [15:0] cinstr_i,
    output logic [31:0] xinstr_o,
    output logic        valid_o,
    output logic        illegal_o,
    output logic        foreign_o
);

    localparam int unsigned NSUB = 2;

    cx_res_t sub [NSUB];

    cx_mem_expand u_mem (
        .cin (cinstr_i),
        .res (sub[0])
    );

    cx_alu_expand #(
        .HAS_BITMANIP (HAS_BITMANIP),
        .HAS_ADDUW    (HAS_ADDUW),
        .HAS_MUL      (HAS_MUL),
        .XLEN64       (XLEN64)
    ) u_alu (
        .cin (cinstr_i),
        .res (sub[1])
    );

    // Merge sub-decoder verdicts; only an accepted word reaches the output.
    always_comb begin
        logic          any_claim;
        logic          any_bad;
        logic [XW-1:0] acc;
        any_claim = 1'b0;
        any_bad   = 1'b0;
        acc       = '0;
        for (int k = 0; k < NSUB; k++) begin
            any_claim = any_claim | sub[k].claim;
            any_bad   = any_bad | (sub[k].claim & sub[k].bad);
            if (sub[k].claim && !sub[k].bad) acc = acc | sub[k].word;
        end
        valid_o   = any_claim & ~any_bad;
        illegal_o = any_claim & any_bad;
        foreign_o = ~any_claim;
        xinstr_o  = acc;
    end

    // Guards: one verdict per input; rejected inputs give a zero word.
    always_comb begin
        p_one_verdict_r10: assert ($onehot({valid_o, illegal_o, foreign_o}))
            else $error("verdict flags not one-hot");
        p_zero_when_rejected_r9: assert (valid_o || xinstr_o == '0)
            else $error("nonzero expansion on a rejected input");
        p_disjoint_spaces_r10: assert (!(sub[0].claim && sub[1].claim))
            else $error("both sub-decoders claimed one input");
    end

endmodule

// File: tb/sim_cinstr_expander.sv
// Bench: sweeps all 65536 inputs through sixteen instances, one per feature
// combination, and compares every output against an arithmetic model.
// Register fields (R1) are checked inside every expansion compare.
module sim_cinstr_expander;

    localparam int NCFG  = 16;
    localparam int LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cin = '0;
    logic [31:0] xo [NCFG];
    logic        vo [NCFG];
    logic        io [NCFG];
    logic        fo [NCFG];

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    // cfg bit0 bit-manip, bit1 address-add, bit2 multiply, bit3 64-bit.
    for (genvar g = 0; g < NCFG; g++) begin : g_cfg
        cinstr_expander #(
            .HAS_BITMANIP (g[0]),
            .HAS_ADDUW    (g[1]),
            .HAS_MUL      (g[2]),
            .XLEN64       (g[3])
        ) u0 (
            .cinstr_i  (cin),
            .xinstr_o  (xo[g]),
            .valid_o   (vo[g]),
            .illegal_o (io[g]),
            .foreign_o (fo[g])
        );
    end

    // Model: returns {foreign, illegal, valid, word}; tag names the requirement.
    function automatic logic [34:0] model(input logic [15:0] c, input int cfg,
                                          output string tag);
        int unsigned b = 8 + c[9:7];
        int unsigned p = 8 + c[4:2];
        int unsigned off;
        int unsigned w = 0;
        bit ok = 1;
        bit bm = cfg[0], au = cfg[1], mu = cfg[2], x64 = cfg[3];
        tag = "R10";
        if (c[1:0] == 2'b00 && c[15:12] == 4'b1000) begin
            case (c[11:10])
                2'd0: begin
                    tag = "R2"; off = c[5] * 2 + c[6];
                    w = (off << 20) + (b << 15) + (4 << 12) + (p << 7) + 3;
                end
                2'd1: begin
                    tag = "R3"; off = c[5] * 2;
                    w = (off << 20) + (b << 15) + ((c[6] ? 1 : 5) << 12) + (p << 7) + 3;
                end
                2'd2: begin
                    tag = "R4"; off = c[5] * 2 + c[6];
                    w = (p << 20) + (b << 15) + (off << 7) + 35;
                end
                default: begin
                    tag = "R4"; off = c[5] * 2; ok = !c[6];
                    w = (p << 20) + (b << 15) + (1 << 12) + (off << 7) + 35;
                end
            endcase
        end else if (c[1:0] == 2'b01 && c[15:10] == 6'b100111 && c[6]) begin
            if (!c[5]) begin
                tag = "R8"; ok = mu;
                w = (1 << 25) + (p << 20) + (b << 15) + (b << 7) + 51;
            end else begin
                case (c[4:2])
                    3'd0: begin tag = "R5"; w = (255 << 20) + (b << 15) + (7 << 12) + (b << 7) + 19; end
                    3'd1: begin tag = "R6"; ok = bm; w = (1540 << 20) + (b << 15) + (1 << 12) + (b << 7) + 19; end
                    3'd2: begin tag = "R6"; ok = bm; w = (128 << 20) + (b << 15) + (4 << 12) + (b << 7) + (x64 ? 59 : 51); end
                    3'd3: begin tag = "R6"; ok = bm; w = (1541 << 20) + (b << 15) + (1 << 12) + (b << 7) + 19; end
                    3'd4: begin tag = "R7"; ok = au && x64; w = (4 << 25) + (b << 15) + (b << 7) + 59; end
                    3'd5: begin tag = "R5"; w = (4095 << 20) + (b << 15) + (4 << 12) + (b << 7) + 19; end
                    default: begin tag = "R9"; ok = 0; end
                endcase
            end
        end else begin
            return {3'b100, 32'd0};
        end
        if (!ok) return {3'b010, 32'd0};
        return {3'b001, w[31:0]};
    endfunction

    // Compare every configuration for the current input.
    task automatic check_all();
        for (int k = 0; k < NCFG; k++) begin
            string tag;
            logic [34:0] exp_v = model(cin, k, tag);
            logic [34:0] act_v = {fo[k], io[k], vo[k], xo[k]};
            checks++;
            if (act_v !== exp_v) begin
                errors++;
                $display("FAIL %s in=%h cfg=%0d actual=%h expected=%h",
                         tag, cin, k, act_v, exp_v);
            end
        end
    endtask

    // Watchdog: an overrun counts as a failed check and ends the run.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > LIMIT && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, LIMIT);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Stimulus: drive after a rising edge, sample at the falling edge.
    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all();  // idle input: R10 foreign verdict
        for (int i = 0; i < 65536; i++) begin
            @(posedge clk);
            cin = i[15:0];
            @(negedge clk);
            check_all();
        end
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule